// File: doc/BRIEF.md
# Interrupt Summary and Mask Controller

This block collects nineteen level-sensitive interrupt lines from expansion slots and on-board peripherals. It exposes them to a host through three byte-wide ports on a small 8-bit I/O interface. A write to a port loads the matching byte of an interrupt mask, and a 1 in the mask disables that source. The mask cannot be read back. A read of the same port returns the raw state of the lines, so software always sees which sources are asserting, whether they are masked or not.

From the unmasked active lines the block forms one registered interrupt request to the processor. It also forms a registered pending vector. This vector names the active unmasked source with the lowest index, so a service routine can take sources one at a time, lowest first, until none remain. Source 4 is the output of a downstream legacy interrupt controller. When it is the chosen source, a separate flag tells the service routine to hand off to that controller and not treat it as a device.

Source numbering, as global bit index:
- 0 to 3: pin A of slots 0 to 3.
- 4: the legacy cascade.
- 5: the disk controller.
- 6: the USB controller.
- 7 to 10: pin B of slots 0 to 3.
- 11 to 14: pin C of slots 0 to 3.
- 15 to 18: pin D of slots 0 to 3.

Top module: `irq_summary_ctrl`

## Requirements
- R1: On reset every mask bit is 1. Until software clears a mask bit, `cpu_irq`, `pend_valid` and `pend_cascade` stay 0, even when all lines are active.
- R2: With `io_addr` = k (k = 0, 1, 2), `io_rdata` equals bits 8k+7..8k of the raw `irq_lines`, whatever the mask holds. Bits 7:3 at address 2 read 0, and address 3 reads 0x00.
- R3: A write strobe with `io_addr` = k (k = 0, 1, 2) loads `io_wdata` into mask bits 8k+7..8k, and no other mask bit changes. A mask bit of 1 disables its source and a 0 enables it.
- R4: `cpu_irq` is registered. At each clock edge it takes the OR over the 19 sources of (line AND NOT mask), using the values present before that edge. It stays 1 for as long as an enabled line is held active.
- R5: `pend_valid` follows the same rule and timing as `cpu_irq`. When `pend_valid` is 1, `pend_idx` holds the lowest index, 0 to 18, of an active unmasked line.
- R6: `pend_cascade` is 1 exactly when `pend_valid` is 1 and `pend_idx` is 4.
- R7: A write strobe with `io_addr` = 3 changes no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 2 | Port select (0, 1, 2 valid) |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Mask byte to write |
| io_rdata | output | 8 | Raw line byte for the selected port |
| irq_lines | input | 19 | Level interrupt inputs, active high |
| cpu_irq | output | 1 | Combined request to the processor |
| pend_valid | output | 1 | A pending source exists |
| pend_idx | output | 5 | Lowest pending source index |
| pend_cascade | output | 1 | Pending source is the legacy cascade |

## Verification
The assertions assume three things about the inputs:
- `irq_lines` is synchronous to `clk`.
- `io_wr` is a single-cycle strobe.
- `io_addr` is stable while it is read.

The stimulus meets these by changing every input only on the falling edge. It holds each pattern for two rising edges, so the mask update and the registered outputs have both settled before a sample is taken. Random writes, sparse random line patterns, an unused-address write and a one-edge latency probe cover the mask, the priority choice and the cascade case.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;
   localparam int unsigned BYTE_BITS = 8;
   typedef enum logic [0:0] {
      PRIO_SCAN  = 1'b0,
      PRIO_ISOL  = 1'b1
   } prio_style_e;
endpackage

// File: rtl/irqsum_mask_bank.sv
module irqsum_mask_bank #(
   parameter int unsigned NUM_SRC   = 19,
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned ADDR_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [7:0]         wr_data,
   output logic [NUM_SRC-1:0] mask
);
   import irqsum_pkg::*;

   generate
      if (NUM_SRC > NUM_PORTS * BYTE_BITS) begin : g_bad_size
         $error("irqsum_mask_bank: too many sources for the port count");
      end
      for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
         localparam int unsigned PORT = b / BYTE_BITS;
         localparam int unsigned LANE = b % BYTE_BITS;
         always_ff @(posedge clk) begin
            if (!rst_n)
               mask[b] <= 1'b1;
            else if (wr_en && (wr_addr == ADDR_W'(PORT)))
               mask[b] <= wr_data[LANE];
         end
      end
   endgenerate

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(mask)); // R3
   AST_UNUSED_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && ($past(wr_addr) >= ADDR_W'(NUM_PORTS))) |-> $stable(mask)); // R7
endmodule

// File: rtl/irqsum_read_mux.sv
module irqsum_read_mux #(
   parameter int unsigned NUM_SRC   = 19,
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned ADDR_W    = 2
) (
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [NUM_SRC-1:0] lines,
   output logic [7:0]         rd_data
);
   import irqsum_pkg::*;
   localparam int unsigned REG_W = NUM_PORTS * BYTE_BITS;

   logic [REG_W-1:0] padded;
   assign padded = REG_W'(lines);

   always_comb begin
      rd_data = '0;
      if (int'(rd_addr) < NUM_PORTS)
         rd_data = padded[int'(rd_addr)*BYTE_BITS +: BYTE_BITS];
   end

   always_comb begin
      if (int'(rd_addr) >= NUM_PORTS)
         AST_RD_UNUSED_ZERO: assert (rd_data == 8'h00); // R2
   end
endmodule

// File: rtl/irqsum_prio_enc.sv
module irqsum_prio_enc #(
   parameter int unsigned NUM_SRC = 19,
   parameter irqsum_pkg::prio_style_e STYLE = irqsum_pkg::PRIO_SCAN,
   localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   assign any = |req;

   generate
      if (STYLE == irqsum_pkg::PRIO_SCAN) begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--)
               if (req[i]) idx = IDX_W'(i);
         end
      end else begin : g_isol
         logic [NUM_SRC-1:0] lowest;
         assign lowest = req & (~req + NUM_SRC'(1));
         always_comb begin
            idx = '0;
            for (int i = 0; i < NUM_SRC; i++)
               if (lowest[i]) idx = idx | IDX_W'(i);
         end
      end
   endgenerate

   always_comb begin
      if (any)
         AST_IDX_IS_SET: assert (req[idx]); // R5
   end
endmodule

// File: rtl/irq_summary_ctrl.sv
module irq_summary_ctrl #(
   parameter int unsigned NUM_SRC     = 19,
   parameter int unsigned NUM_PORTS   = 3,
   parameter int unsigned CASCADE_BIT = 4,
   parameter irqsum_pkg::prio_style_e PRIO_STYLE = irqsum_pkg::PRIO_SCAN,
   localparam int unsigned ADDR_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic               io_wr,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   input  logic [NUM_SRC-1:0] irq_lines,
   output logic               cpu_irq,
   output logic               pend_valid,
   output logic [IDX_W-1:0]   pend_idx,
   output logic               pend_cascade
);
   generate
      if (CASCADE_BIT >= NUM_SRC) begin : g_bad_cascade
         $error("irq_summary_ctrl: cascade bit outside source range");
      end
   endgenerate

   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] active;
   logic               any_act;
   logic [IDX_W-1:0]   low_idx;

   irqsum_mask_bank #(.NUM_SRC(NUM_SRC), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_en(io_wr), .wr_addr(io_addr),
      .wr_data(io_wdata), .mask(mask));

   irqsum_read_mux #(.NUM_SRC(NUM_SRC), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_rd (
      .rd_addr(io_addr), .lines(irq_lines), .rd_data(io_rdata));

   assign active = irq_lines & ~mask;

   irqsum_prio_enc #(.NUM_SRC(NUM_SRC), .STYLE(PRIO_STYLE)) u_enc (
      .req(active), .any(any_act), .idx(low_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_irq      <= 1'b0;
         pend_valid   <= 1'b0;
         pend_idx     <= '0;
         pend_cascade <= 1'b0;
      end else begin
         cpu_irq      <= |active;
         pend_valid   <= any_act;
         pend_idx     <= low_idx;
         pend_cascade <= any_act && (low_idx == IDX_W'(CASCADE_BIT));
      end
   end

   AST_VALID_TRACKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid == cpu_irq); // R5
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (int'(pend_idx) < NUM_SRC)); // R5
   AST_CASCADE_ONLY_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cascade |-> (pend_valid && pend_idx == IDX_W'(CASCADE_BIT))); // R6
   AST_CASCADE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && pend_idx == IDX_W'(CASCADE_BIT)) |-> pend_cascade); // R6
   AST_IRQ_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && cpu_irq) |-> ($past(irq_lines) != '0)); // R4
endmodule

// File: tb/irq_summary_ctrl_test.sv
module irq_summary_ctrl_test;
   localparam int N = 19;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  io_addr = '0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [N-1:0] irq_lines = '0;
   logic        cpu_irq, pend_valid, pend_cascade;
   logic [4:0]  pend_idx;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [N-1:0] m_mask;

   always #2 clk = ~clk;

   irq_summary_ctrl uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .irq_lines(irq_lines),
      .cpu_irq(cpu_irq), .pend_valid(pend_valid), .pend_idx(pend_idx),
      .pend_cascade(pend_cascade));

   function automatic logic [N-1:0] f_active(input logic [N-1:0] l, input logic [N-1:0] m);
      return l & ~m;
   endfunction

   function automatic int f_low(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return 0;
   endfunction

   function automatic logic [7:0] f_rd(input logic [1:0] a, input logic [N-1:0] l);
      logic [23:0] p;
      p = 24'(l);
      if (a == 2'd3) return 8'h00;
      return p[a*8 +: 8];
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_outputs(input logic [N-1:0] l);
      logic [N-1:0] act;
      act = f_active(l, m_mask);
      check("R4 cpu_irq", int'(cpu_irq), int'(|act));
      check("R5 pend_valid", int'(pend_valid), int'(|act));
      if (|act) check("R5 pend_idx", int'(pend_idx), f_low(act));
      check("R6 pend_cascade", int'(pend_cascade), int'((|act) && f_low(act) == 4));
      check("R2 io_rdata", int'(io_rdata), int'(f_rd(io_addr, l)));
   endtask

   // Drive after a falling edge; sample two rising edges later.
   task automatic step(input logic [1:0] a, input logic w, input logic [7:0] d, input logic [N-1:0] l);
      io_addr = a; io_wr = w; io_wdata = d; irq_lines = l;
      @(posedge clk);
      if (w && a < 2'd3)
         for (int b = 0; b < 8; b++)
            if (a*8 + b < N) m_mask[a*8 + b] = d[b];
      @(negedge clk);
      io_wr = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_outputs(l);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] l;
      int unsigned seed;
      seed = 32'd13579;
      void'($urandom(seed));
      m_mask = '1;
      irq_lines = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      // R1: reset leaves everything masked
      check("R1 cpu_irq after reset", int'(cpu_irq), 0);
      check("R1 pend_valid after reset", int'(pend_valid), 0);
      check("R1 pend_cascade after reset", int'(pend_cascade), 0);
      // R2: reads ignore mask, reserved bits zero
      for (int a = 0; a < 4; a++) begin
         io_addr = 2'(a); #1;
         check("R2 raw read all-ones", int'(io_rdata), int'(f_rd(2'(a), '1)));
      end
      // R3: open one byte at a time
      step(2'd1, 1'b1, 8'h00, '1);
      check("R3 byte1 open lowest", int'(pend_idx), 8);
      step(2'd0, 1'b1, 8'hEF, '1);
      check("R6 cascade when only 4 open below", int'(pend_cascade), 1);
      step(2'd0, 1'b1, 8'h00, 19'h00010);
      step(2'd0, 1'b0, 8'h00, 19'h00030);
      step(2'd0, 1'b0, 8'h00, 19'h00000);
      check("R4 level drop clears", int'(cpu_irq), 0);
      step(2'd2, 1'b1, 8'h00, 19'h40000);
      check("R5 top source index", int'(pend_idx), 18);
      // R7: write to unused address leaves mask open
      step(2'd3, 1'b1, 8'hFF, 19'h00001);
      check("R7 unused write ignored", int'(cpu_irq), 1);
      // R4: one-edge latency
      step(2'd0, 1'b1, 8'h00, 19'h0);
      @(negedge clk);
      irq_lines = 19'h00004;
      #1;
      check("R4 not combinational", int'(cpu_irq), 0);
      @(posedge clk); @(negedge clk);
      check("R4 one edge latency", int'(cpu_irq), 1);
      check("R5 latency idx", int'(pend_idx), 2);
      // Random mix
      for (int it = 0; it < 400; it++) begin
         l = N'($urandom) & N'($urandom) & N'($urandom);
         step(2'($urandom % 4), 1'($urandom % 2), 8'($urandom), l);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule